// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block turns a stream of oscillator clock-enable pulses (nominally 32768 per second) into a one-cycle seconds strobe. It corrects crystal frequency error digitally. The length of selected seconds is changed by a signed, even number of oscillator pulses. Each step of two pulses applied once every twenty seconds moves the timebase by roughly 3 ppm. That gives a setting precision of about ±1.5 ppm.

Software writes a 7-bit trim code. The calendar reports the current seconds value in BCD, and the block uses it to see when a corrected second begins. Only seconds that start at 00, 20 or 40 take the corrected length; every other second uses the nominal count. The length of each second is fixed at the moment that second begins, so a trim write never changes a second already running. Raw oscillator-rate outputs are generated elsewhere and are never trimmed.

Top module: `trim_prescaler`

## Requirements
- R1: A second that is not corrected lasts exactly NOM_CYCLES cycles with `osc_en` high. Cycles with `osc_en` low do not advance the count.
- R2: A second is corrected only when `sec_bcd`, sampled as that second begins, equals 8'h00, 8'h20 or 8'h40. Any other value (for example 8'h01, 8'h10, 8'h21, 8'h59) gives NOM_CYCLES.
- R3: With `trim_code[6]` = 0 and `trim_code[5:1]` not all zero, a corrected second lasts NOM_CYCLES + (trim_code[5:0] − 1) × 2 pulses. For example, 7'b0111111 adds 124 and 7'b0000010 adds 2.
- R4: With `trim_code[6]` = 1 and `trim_code[5:1]` not all zero, a corrected second lasts NOM_CYCLES − ((~trim_code[5:0]) + 1) × 2 pulses, where ~ is the 6-bit inverse. For example, 7'b1111110 removes 4 and 7'b1000010 removes 124.
- R5: When `trim_code[5:1]` is all zero, every second lasts NOM_CYCLES, whatever the values of bits 6 and 0.
- R6: Reset clears the trim code to 7'b0000000 and holds `sec_tick` low. The first second after reset starts on the first clock edge after `rst_n` rises.
- R7: A trim write that lands during a second does not change that second's length. It applies from the next second that begins.
- R8: `sec_tick` is high for exactly one clock cycle. It goes high on the clock edge that samples the final `osc_en` pulse of a second. The pulse count then restarts from zero, and the next second's length is chosen on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| trim_wr | input | 1 | Write strobe for the trim code |
| trim_code | input | 7 | Trim code: bit 6 is the direction, bits 5:0 the offset-by-one magnitude |
| sec_bcd | input | 8 | Current seconds value in BCD, from the calendar |
| sec_tick | output | 1 | One-cycle strobe at the end of each second |

## Verification
The bench builds the block with NOM_CYCLES = 256 instead of 32768. This keeps each second to a few hundred pulses, so every extreme trim code (+124 and −124) and every window second can be measured end to end in a short run. The offset arithmetic and the BCD window do not depend on the nominal count, so the same cases cover the full-size build. The bench also sends `osc_en` with gaps, which shows that only enabled cycles are counted.

// File: rtl/tpre_pkg.sv
package tpre_pkg;
  localparam int TRIM_W  = 7;
  localparam int MAG_W   = TRIM_W - 1;
  localparam int STEP    = 2;
  localparam int MAX_ADJ = ((1 << MAG_W) - 2) * STEP;

  // Signed pulse offset applied to a corrected second
  function automatic int trim_offset(input logic [TRIM_W-1:0] code);
    logic [MAG_W-1:0] inv;
    inv = ~code[MAG_W-1:0];
    if (code[MAG_W-1:1] == '0)
      return 0;
    else if (!code[TRIM_W-1])
      return (int'(code[MAG_W-1:0]) - 1) * STEP;
    else
      return -((int'(inv) + 1) * STEP);
  endfunction
endpackage

// File: rtl/tpre_trim_reg.sv
module tpre_trim_reg
  import tpre_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [TRIM_W-1:0]       wdata,
  output logic signed [OFF_W-1:0] offset
);
  logic [TRIM_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   code_q <= '0;
    else if (wr)  code_q <= wdata;
  end

  assign offset = OFF_W'(trim_offset(code_q));

  // R3
  offset_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offset[0] == 1'b0);
  // R4
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(offset) <= MAX_ADJ) && (int'(offset) >= -MAX_ADJ));
  // R7
  trim_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (code_q == $past(wdata)));
endmodule

// File: rtl/tpre_adj_window.sv
module tpre_adj_window #(
  parameter int SLOTS     = 3,
  parameter int TENS_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sec_bcd,
  output logic       hit
);
  logic [SLOTS-1:0] slot_hit;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam logic [3:0] TENS = 4'(i * TENS_STEP);
    assign slot_hit[i] = (sec_bcd == {TENS, 4'h0});
  end

  assign hit = |slot_hit;

  // R2
  window_units_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (sec_bcd[3:0] == 4'h0));
  // R2
  window_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hit));
endmodule

// File: rtl/tpre_counter.sv
module tpre_counter
  import tpre_pkg::*;
#(
  parameter int NOM_CYCLES = 32768,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic [CNT_W-1:0] term_next,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term_q;
  logic [CNT_W-1:0] term_eff;
  logic             load_pend;
  logic             last_pulse;

  assign term_eff   = load_pend ? term_next : term_q;
  assign last_pulse = osc_en && (cnt == term_eff - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      term_q    <= CNT_W'(NOM_CYCLES);
      load_pend <= 1'b1;
      tick      <= 1'b0;
    end else begin
      tick <= last_pulse;
      if (load_pend) begin
        term_q    <= term_next;
        load_pend <= 1'b0;
      end
      if (last_pulse) begin
        cnt       <= '0;
        load_pend <= 1'b1;
      end else if (osc_en) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R8
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R8
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt == '0) && load_pend);
  // R7
  term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pend |=> $stable(term_q));
  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pend |-> (cnt < term_q));
  // R3
  term_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(term_q) <= NOM_CYCLES + MAX_ADJ) && (int'(term_q) >= NOM_CYCLES - MAX_ADJ));
endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler
  import tpre_pkg::*;
#(
  parameter int NOM_CYCLES = 32768,
  parameter int SLOTS      = 3,
  parameter int TENS_STEP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              trim_wr,
  input  logic [TRIM_W-1:0] trim_code,
  input  logic [7:0]        sec_bcd,
  output logic              sec_tick
);
  localparam int CNT_W = $clog2(NOM_CYCLES + MAX_ADJ + 1);
  localparam int OFF_W = $clog2(MAX_ADJ + 1) + 1;

  logic signed [OFF_W-1:0] offset;
  logic                    adj_hit;
  int                      term_i;
  logic [CNT_W-1:0]        term_next;

  tpre_trim_reg #(.OFF_W(OFF_W)) u_trim (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (trim_wr),
    .wdata  (trim_code),
    .offset (offset)
  );

  tpre_adj_window #(.SLOTS(SLOTS), .TENS_STEP(TENS_STEP)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .sec_bcd (sec_bcd),
    .hit     (adj_hit)
  );

  always_comb begin
    term_i    = NOM_CYCLES + (adj_hit ? int'(offset) : 0);
    term_next = CNT_W'(term_i);
  end

  tpre_counter #(.NOM_CYCLES(NOM_CYCLES), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_en    (osc_en),
    .term_next (term_next),
    .tick      (sec_tick)
  );

  // R1
  tick_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(osc_en));
  // R5
  no_adj_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adj_hit |-> (term_next == CNT_W'(NOM_CYCLES)));
endmodule

// File: tb/trim_prescaler_tb.sv
`timescale 1ns/1ps
module trim_prescaler_tb;
  localparam int NOM = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       trim_wr = 1'b0;
  logic [6:0] trim_code = '0;
  logic [7:0] sec_bcd = '0;
  logic       sec_tick;

  int tests = 0;
  int fails = 0;
  int phase = 0;

  always #2.5 clk = ~clk;

  trim_prescaler #(.NOM_CYCLES(NOM)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_en    (osc_en),
    .trim_wr   (trim_wr),
    .trim_code (trim_code),
    .sec_bcd   (sec_bcd),
    .sec_tick  (sec_tick)
  );

  typedef struct packed {
    logic [6:0]  code;
    logic [7:0]  sec;
    logic [15:0] len;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{7'b0101001, 8'h00, 16'd336},  // R3 +80
    '{7'b0101001, 8'h01, 16'd256},  // R2 outside window
    '{7'b1111110, 8'h20, 16'd252},  // R4 -4
    '{7'b0000001, 8'h40, 16'd256},  // R5
    '{7'b1000000, 8'h00, 16'd256},  // R5
    '{7'b0111111, 8'h40, 16'd380},  // R3 +124
    '{7'b1000010, 8'h20, 16'd132},  // R4 -124
    '{7'b0000010, 8'h00, 16'd258},  // R3 +2
    '{7'b1111111, 8'h40, 16'd254},  // R4 -2
    '{7'b0111111, 8'h59, 16'd256},  // R2
    '{7'b0111111, 8'h21, 16'd256},  // R2
    '{7'b0000011, 8'h20, 16'd260},  // R3 +4
    '{7'b1000001, 8'h40, 16'd256},  // R5
    '{7'b0111111, 8'h10, 16'd256}   // R2
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive gapped osc_en until sec_tick; return the number of pulses sent.
  task automatic run_second(input logic [7:0] s, input int exp, input bit do_wr,
                            input logic [6:0] wcode, input string tag, input bit chk_strobe);
    int  n = 0;
    int  guard = 0;
    bit  wrote = 0;
    bit  first = 1;
    sec_bcd = s;
    osc_en  = 1'b0;
    forever begin
      @(negedge clk);
      if (first && chk_strobe) begin
        check(sec_tick == 1'b0, "R8 strobe width", int'(sec_tick), 0);
      end
      first = 0;
      if (sec_tick) break;
      guard++;
      if (guard > 4000) begin
        check(1'b0, "timeout", n, exp);
        break;
      end
      phase++;
      osc_en = (phase % 3 != 0);
      if (osc_en) n++;
      if (do_wr && !wrote && n == 40) begin
        trim_wr = 1'b1;
        trim_code = wcode;
        wrote = 1;
      end else begin
        trim_wr = 1'b0;
      end
    end
    osc_en  = 1'b0;
    trim_wr = 1'b0;
    check(n == exp, tag, n, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    osc_en = 1'b0;
    trim_wr = 1'b0;
    sec_bcd = 8'h00;
    repeat (4) @(negedge clk);
    // R6: strobe low in reset
    check(sec_tick == 1'b0, "R6 reset tick", int'(sec_tick), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #500us;
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R6: trim is neutral after reset even in a window second
    run_second(8'h00, NOM, 1'b0, 7'd0, "R6 first second", 1'b0);

    for (int i = 0; i < NV; i++) begin
      // R1: filler non-window second under any trim, loads the next code mid-second
      run_second(8'h01, NOM, 1'b1, VECS[i].code, "R1 nominal filler", 1'b1);
      run_second(VECS[i].sec, int'(VECS[i].len), 1'b0, 7'd0, "R2/R3/R4/R5 table", 1'b1);
    end

    // R7: write during a corrected second leaves it alone, applies next time
    run_second(8'h01, NOM, 1'b1, 7'b0111111, "R1 filler", 1'b1);
    run_second(8'h00, NOM + 124, 1'b1, 7'b1111110, "R7 in-progress kept", 1'b1);
    run_second(8'h20, NOM - 4, 1'b0, 7'd0, "R7 next second uses new code", 1'b1);
    run_second(8'h40, NOM - 4, 1'b0, 7'd0, "R3/R4 code persists", 1'b1);

    // R6: reset mid-run returns the trim code to neutral
    do_reset();
    run_second(8'h00, NOM, 1'b0, 7'd0, "R6 trim cleared", 1'b0);
    run_second(8'h20, NOM, 1'b0, 7'd0, "R6 trim cleared 20", 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule